// File: doc/BRIEF.md
# Supervisory Watchdog with Failsafe Boot

This block supervises board start-up. Software reaches it through a byte-wide register port with a write strobe, a read strobe, a 2-bit offset and 8-bit data. It holds a reload period in whole seconds and counts down once per second, using a prescaler that divides the core clock. When the count reaches zero while the watchdog is enabled, an expiry occurs. The expiry can pulse a board reset request and pulse an active-low timeout line. If the recovery enable was the enable in use, the expiry also raises a sticky flag that tells the boot logic to start the failsafe image next time.

Two enables exist: a normal one and a recovery one. Either of them keeps the counter running. A lock bit freezes the control register until the next board reset. Writing one specific magic byte to the kick register reloads the counter. A timeout of zero followed by a kick forces an immediate expiry, so software can request a reset into failsafe mode on purpose. A strap input chooses whether the normal enable comes up set after reset.

Top module: `sup_wdog`

## Requirements
- R1: Reads return data one cycle after the read strobe. Offset 0 returns control, offset 1 returns the reload period, offset 2 returns the remaining seconds and offset 3 returns 0. Control bits 5:3 are not stored and read as 0.
- R2: After power-on reset or board reset, control reads 0x40 | strap (bit 6 set, bit 0 equal to the strap), and both the reload period and the count equal DFLT_TIMEOUT.
- R3: The counter runs while control bit 0 (normal) or bit 1 (recovery) is set. It drops by one after every CLK_HZ running cycles and stops at 0. While both bits are clear, the count holds and the prescaler is cleared.
- R4: Writing 0x6B to offset 2 loads the count from the reload period and restarts the one-second prescaler. Any other value written to offset 2 has no effect.
- R5: An expiry happens in the first cycle in which the watchdog is running with a count of 0. Only one expiry happens per arming. A kick or a disable re-arms it.
- R6: With control bit 6 set at expiry, sys_rst_o is high for exactly PULSE_CYC cycles, starting in the cycle after the expiry. With bit 6 clear, sys_rst_o stays low.
- R7: With control bit 7 set at expiry, wdt_to_n_o is low for exactly PULSE_CYC cycles with the same timing. With bit 7 clear, it stays high.
- R8: An expiry with control bit 1 set raises failsafe_o. The flag survives a board reset and is cleared only by power-on reset.
- R9: While control bit 2 (lock) is set, writes to offset 0 are ignored until the next board reset. Writes to the reload period and kicks still take effect.
- R10: A reload period of 0, then a kick, then a write that sets an enable gives an expiry in the cycle after the enabling write. The outputs respond one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_i | input | 1 | Synchronous power-on reset, active high; clears everything |
| brd_rst_i | input | 1 | Synchronous board reset, active high; keeps the failsafe flag and the output pulses |
| start_en_i | input | 1 | Strap: normal enable value taken at reset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| sys_rst_o | output | 1 | Board reset request pulse, active high |
| wdt_to_n_o | output | 1 | Timeout line pulse, active low |
| failsafe_o | output | 1 | Sticky flag: boot the failsafe image next |

## Verification
The countdown is exercised four ways. In the first, it runs from the reset default with the reset output enabled. In the second, it runs from a programmed period with the recovery enable and only the timeout line enabled. This separates the two output masks and shows whether the failsafe flag depends on which enable is set. In the third, the reload period is forced to zero while the watchdog is locked and running. This confirms that reload and kick still work under the lock while control writes are dropped. In the fourth, the zero-period kick is followed by an enabling write, which pins the exact cycle of a forced expiry. A kick with a byte one off the magic value, and a long idle stretch with both enables clear, show whether the count moves when it must not. Board reset and power-on reset are applied separately to tell apart which state each of them clears.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_TOUT  = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_KICK  = 2'd2;
  localparam int B_EN_NORM = 0;
  localparam int B_EN_RECO = 1;
  localparam int B_LOCK    = 2;
  localparam int B_RST_EN  = 6;
  localparam int B_LINE_EN = 7;
  localparam logic [DATA_W-1:0] CTRL_MASK  = 8'hC7;
  localparam logic [DATA_W-1:0] KICK_MAGIC = 8'h6B;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DFLT_TIMEOUT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_en,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cnt,
  output logic [DATA_W-1:0] ctrl,
  output logic [DATA_W-1:0] tout,
  output logic              kick,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rd_mux;

  assign kick = wr && (addr == OFS_KICK) && (wdata == KICK_MAGIC);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= DATA_W'(1 << B_RST_EN) | DATA_W'(start_en);
      tout <= DATA_W'(DFLT_TIMEOUT);
    end else if (wr) begin
      if (addr == OFS_CTRL && !ctrl[B_LOCK]) ctrl <= wdata & CTRL_MASK;
      if (addr == OFS_TOUT) tout <= wdata;
    end
  end

  always_comb begin
    case (addr)
      OFS_CTRL: rd_mux = ctrl;
      OFS_TOUT: rd_mux = tout;
      OFS_KICK: rd_mux = cnt;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/wdog_tick.sv
module wdog_tick #(
  parameter int CLK_HZ = 100_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLK_HZ - 1);
  logic [PW-1:0] pre;

  assign tick = run && (pre == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) pre <= '0;
    else if (pre == LAST)       pre <= '0;
    else                        pre <= pre + 1'b1;
  end
endmodule

// File: rtl/wdog_down.sv
module wdog_down
  import wdog_pkg::*;
#(
  parameter int DFLT_TIMEOUT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              kick,
  input  logic              tick,
  input  logic [DATA_W-1:0] tout,
  output logic [DATA_W-1:0] cnt,
  output logic              expire
);
  logic fired;

  assign expire = !rst && run && (cnt == '0) && !fired;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= DATA_W'(DFLT_TIMEOUT);
      fired <= 1'b0;
    end else begin
      if (kick)                    cnt <= tout;
      else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
      if (kick || !run)            fired <= 1'b0;
      else if (expire)             fired <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_stretch.sv
module wdog_stretch #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic q
);
  localparam int LW = $clog2(LEN + 1);
  logic [LW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left <= '0;
      q    <= 1'b0;
    end else if (start) begin
      left <= LW'(LEN - 1);
      q    <= 1'b1;
    end else if (left != '0) begin
      left <= left - 1'b1;
    end else begin
      q <= 1'b0;
    end
  end
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
  import wdog_pkg::*;
#(
  parameter int CLK_HZ       = 100_000_000,
  parameter int DFLT_TIMEOUT = 10,
  parameter int PULSE_CYC    = 16
) (
  input  logic        clk,
  input  logic        por_i,
  input  logic        brd_rst_i,
  input  logic        start_en_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [1:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        sys_rst_o,
  output logic        wdt_to_n_o,
  output logic        failsafe_o
);
  localparam int NOUT = 2;

  logic              rst_any;
  logic [DATA_W-1:0] ctrl_q, tout_q, cnt_q;
  logic              kick, tick, run, exp_evt;
  logic [NOUT-1:0]   pulse_go, pulse_q;

  assign rst_any = por_i | brd_rst_i;
  assign run     = ctrl_q[B_EN_NORM] | ctrl_q[B_EN_RECO];

  wdog_regs #(.DFLT_TIMEOUT(DFLT_TIMEOUT)) u_regs (
    .clk(clk), .rst(rst_any), .start_en(start_en_i),
    .wr(wr_i), .rd(rd_i), .addr(addr_i), .wdata(wdata_i),
    .cnt(cnt_q), .ctrl(ctrl_q), .tout(tout_q), .kick(kick), .rdata(rdata_o)
  );

  wdog_tick #(.CLK_HZ(CLK_HZ)) u_tick (
    .clk(clk), .rst(rst_any), .run(run), .restart(kick), .tick(tick)
  );

  wdog_down #(.DFLT_TIMEOUT(DFLT_TIMEOUT)) u_down (
    .clk(clk), .rst(rst_any), .run(run), .kick(kick), .tick(tick),
    .tout(tout_q), .cnt(cnt_q), .expire(exp_evt)
  );

  assign pulse_go[0] = exp_evt & ctrl_q[B_RST_EN];
  assign pulse_go[1] = exp_evt & ctrl_q[B_LINE_EN];

  generate
    for (genvar i = 0; i < NOUT; i++) begin : g_out
      wdog_stretch #(.LEN(PULSE_CYC)) u_str (
        .clk(clk), .rst(por_i), .start(pulse_go[i]), .q(pulse_q[i])
      );
    end
  endgenerate

  assign sys_rst_o  = pulse_q[0];
  assign wdt_to_n_o = ~pulse_q[1];

  always_ff @(posedge clk) begin
    if (por_i)                           failsafe_o <= 1'b0;
    else if (exp_evt && ctrl_q[B_EN_RECO]) failsafe_o <= 1'b1;
  end
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
  input logic       clk,
  input logic       por,
  input logic       brd_rst,
  input logic [7:0] ctrl,
  input logic [7:0] cnt,
  input logic       kick,
  input logic       exp_evt,
  input logic       sys_rst,
  input logic       wdt_to_n,
  input logic       failsafe
);
  // R6
  rst_rise_chk: assert property (@(posedge clk) disable iff (por)
    $rose(sys_rst) |-> $past(exp_evt));
  // R7
  line_fall_chk: assert property (@(posedge clk) disable iff (por)
    $fell(wdt_to_n) |-> $past(exp_evt));
  // R8
  failsafe_hold_chk: assert property (@(posedge clk) disable iff (por)
    failsafe |=> failsafe);
  // R9
  lock_freeze_chk: assert property (@(posedge clk) disable iff (por || brd_rst)
    ctrl[2] |=> $stable(ctrl));
  // R3
  halt_chk: assert property (@(posedge clk) disable iff (por || brd_rst)
    (ctrl[1:0] == 2'b00 && !kick) |=> $stable(cnt));
endmodule

bind sup_wdog wdog_chk u_chk (
  .clk(clk), .por(por_i), .brd_rst(brd_rst_i), .ctrl(ctrl_q), .cnt(cnt_q),
  .kick(kick), .exp_evt(exp_evt), .sys_rst(sys_rst_o), .wdt_to_n(wdt_to_n_o),
  .failsafe(failsafe_o)
);

// File: tb/sup_wdog_bench.sv
`timescale 1ns/1ps
module sup_wdog_bench;
  localparam int HZ = 20, DT = 3, PC = 4;

  logic clk = 0, por = 1, brd = 0, strap = 1, wr = 0, rd = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic sys_rst, to_n, fsafe;
  int n_chk = 0, n_fail = 0, cyc = 0;

  // reference model state
  int m_ctrl, m_to, m_cnt, m_pre, m_done, m_rd, m_lr, m_ll, m_fs;

  always #5 clk = ~clk;

  sup_wdog #(.CLK_HZ(HZ), .DFLT_TIMEOUT(DT), .PULSE_CYC(PC)) u_sup_wdog (
    .clk(clk), .por_i(por), .brd_rst_i(brd), .start_en_i(strap),
    .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .sys_rst_o(sys_rst), .wdt_to_n_o(to_n), .failsafe_o(fsafe));

  always @(posedge clk) begin
    int run, kick, tick, ex;
    run  = (m_ctrl & 3) != 0;
    kick = wr && addr == 2 && wdata == 8'h6B;
    tick = run && m_pre == HZ - 1;
    ex   = !(por || brd) && run && m_cnt == 0 && !m_done;
    if (por) begin m_lr = 0; m_ll = 0; m_fs = 0; end
    else begin
      if (ex && m_ctrl[6]) m_lr = PC; else if (m_lr > 0) m_lr--;
      if (ex && m_ctrl[7]) m_ll = PC; else if (m_ll > 0) m_ll--;
      if (ex && m_ctrl[1]) m_fs = 1;
    end
    if (por || brd) begin
      m_ctrl = 8'h40 | strap; m_to = DT; m_cnt = DT; m_pre = 0; m_done = 0; m_rd = 0;
    end else begin
      if (rd) m_rd = (addr == 0) ? m_ctrl : (addr == 1) ? m_to : (addr == 2) ? m_cnt : 0;
      if (kick) m_cnt = m_to; else if (tick && m_cnt != 0) m_cnt--;
      if (kick || !run) m_pre = 0; else if (m_pre == HZ - 1) m_pre = 0; else m_pre++;
      if (kick || !run) m_done = 0; else if (ex) m_done = 1;
      if (wr && addr == 1) m_to = wdata;
      if (wr && addr == 0 && !m_ctrl[2]) m_ctrl = wdata & 8'hC7;
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      if (n_fail < 30) $display("FAIL %s act=%0h exp=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (cyc > 2) begin
      check("R1 rdata", rdata, m_rd);
      check("R6 sys_rst", sys_rst, m_lr > 0);
      check("R7 wdt_to_n", to_n, !(m_ll > 0));
      check("R8 failsafe", fsafe, m_fs);
    end
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 20000);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wreg(int a, int d);
    @(negedge clk); wr = 1; addr = 2'(a); wdata = 8'(d);
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(int a, int exp, string req);
    @(negedge clk); rd = 1; addr = 2'(a);
    @(negedge clk); rd = 0;
    check(req, rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int hi;
    idle(3); por = 0;
    // R2 reset defaults with strap set
    rreg(0, 8'h41, "R2 ctrl");
    rreg(1, DT, "R2 tout");
    rreg(2, DT, "R2 cnt");
    rreg(3, 0, "R1 ofs3");
    // R3/R5/R6 run down from default; measure reset pulse width
    hi = 0;
    repeat (DT * HZ + 20) begin @(negedge clk); if (sys_rst) hi++; end
    check("R6 pulse width", hi, PC);
    check("R8 no failsafe on normal enable", fsafe, 0);
    // board reset with strap clear: stays disabled
    strap = 0; @(negedge clk); brd = 1; idle(2); brd = 0;
    rreg(0, 8'h40, "R2 ctrl strap0");
    idle(3 * HZ);
    rreg(2, DT, "R3 halted");
    // R1 unused ctrl bits
    wreg(0, 8'h38);
    rreg(0, 8'h00, "R1 masked bits");
    // recovery enable, timeout line only
    wreg(1, 5);
    wreg(2, 8'h6B);
    wreg(0, 8'h82);
    idle(HZ + 5);
    rreg(2, 4, "R3 one tick");
    wreg(2, 8'h6A);
    rreg(2, 4, "R4 wrong byte ignored");
    wreg(2, 8'h6B);
    rreg(2, 5, "R4 magic reload");
    hi = 0;
    repeat (5 * HZ + 20) begin @(negedge clk); if (!to_n) hi++; end
    check("R7 line width", hi, PC);
    check("R8 failsafe set", fsafe, 1);
    @(negedge clk); brd = 1; idle(2); brd = 0;
    check("R8 survives board reset", fsafe, 1);
    // R9 lock while running, then forced expiry through timeout/kick
    wreg(0, 8'h45);
    wreg(0, 8'h00);
    rreg(0, 8'h45, "R9 ctrl locked");
    wreg(1, 0);
    rreg(1, 0, "R9 tout writable");
    wreg(2, 8'h6B);
    check("R9 kick under lock", sys_rst, 0);
    @(negedge clk);
    check("R9 kick under lock expiry", sys_rst, 1);
    idle(PC + 2);
    // R10 forced expiry after power-on reset
    @(negedge clk); por = 1; idle(2); por = 0;
    check("R8 cleared by por", fsafe, 0);
    wreg(1, 0);
    wreg(2, 8'h6B);
    wreg(0, 8'hC1);
    check("R10 not yet", sys_rst, 0);
    @(negedge clk);
    check("R10 reset", sys_rst, 1);
    check("R10 line", to_n, 0);
    idle(PC + 4);
    check("R5 single expiry", sys_rst, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule